// File: doc/BRIEF.md
# Dual-Source Instruction Fetch with Execution-Unit Demand Predecode

This block sits at the front of a processor whose execution units can be swapped at runtime. Each cycle it can accept a group of four 16-bit instructions. The group comes either from a 64-bit instruction-memory word or from a trace cache. The choice depends on whether the trace cache reports a hit for the current fetch address. Until the first group after reset has been taken, the trace cache is not consulted, so a program always begins from instruction memory.

Each slot of the fetched group is predecoded into a coarse class: integer ALU, multiply/divide, load/store, or other. The classes of the valid slots are merged into a three-bit demand vector. A configuration manager reads this vector to learn which kinds of execution unit the incoming code needs. The group, its per-slot valid bits, its classes and the demand vector are registered and handed to the decoder through a valid/ready pair. They stay frozen while the decoder stalls.

A redirect input drops whatever group is held and restarts fetch at a new halfword address. Slots that lie before that halfword inside the 64-bit word are marked invalid.

Top module: `trace_fetch_sel`

## Requirements
- R1: During and right after reset, grpValid, grpSlotValid, grpClass and unitReq are all zero, tcLookupEn is 0 and tcLookupAddr equals RESET_PC.
- R2: The first group loaded after reset comes from instruction memory (grpFromTc = 0) even if tcHit is 1; tcLookupEn stays 0 until that group is loaded and is 1 afterwards.
- R3: imemAddr is the fetch PC with its low three bits cleared. In a memory group, slot i is imemData[16*i+15:16*i], so slot 0 holds the lowest address.
- R4: In a group from instruction memory, slot i is valid exactly when i >= PC[2:1] of the fetch PC; the last slot is always valid.
- R5: When a group is loaded while tcHit = 1 and tcLookupEn = 1, the group is taken from tcData. All four slots are valid, grpFromTc is 1, and the next fetch PC is tcNextPc with bit 0 cleared.
- R6: When a group is loaded without a trace-cache hit, the next fetch PC is imemAddr + 8.
- R7: Each valid slot gets a 2-bit class in grpClass[2*i+1:2*i]. The codes are 0 = other, 1 = ALU, 2 = MDU and 3 = LSU. MDU means opcode bits [15:6] = 0100001101. LSU means bits [15:11] = 01001, or bits [15:12] are 5, 6, 7, 8, 9 or C (hex). ALU means bits [15:14] = 00, or bits [15:11] = 01000 that is not MDU, or bits [15:12] = A, or bits [15:8] = B0. Every other opcode is class 0.
- R8: unitReq bit 0 (ALU), bit 1 (MDU) and bit 2 (LSU) are each the OR over valid slots of that class. An invalid slot reports class 0 and adds nothing.
- R9: While grpValid = 1, decReady = 0 and redirValid = 0, the next cycle keeps grpValid, grpInstr, grpSlotValid, grpClass, unitReq, grpFromTc, grpPc and the fetch PC unchanged.
- R10: redirValid = 1 takes priority over loading. On the next cycle grpValid, grpSlotValid, grpClass and unitReq are zero and the fetch PC is redirPc with bit 0 cleared.
- R11: A group is loaded whenever redirValid = 0 and either grpValid = 0 or decReady = 1; grpPc then holds the fetch PC it was read from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| imemAddr | output | ADDR_W | 64-bit aligned instruction-memory read address |
| imemData | input | 64 | Instruction-memory word for imemAddr, same cycle |
| tcLookupEn | output | 1 | Trace-cache lookup is honoured this cycle |
| tcLookupAddr | output | ADDR_W | Current fetch PC presented to the trace cache |
| tcHit | input | 1 | Trace cache holds a group for tcLookupAddr |
| tcData | input | 64 | Trace-cache group, four slots |
| tcNextPc | input | ADDR_W | Fetch PC that follows the trace-cache group |
| redirValid | input | 1 | Restart fetch at redirPc |
| redirPc | input | ADDR_W | New halfword fetch address |
| grpValid | output | 1 | Group to decoder is valid |
| decReady | input | 1 | Decoder accepts the group |
| grpInstr | output | 64 | Four fetched instructions |
| grpSlotValid | output | 4 | Per-slot valid bits |
| grpClass | output | 8 | Per-slot 2-bit predecode class |
| grpFromTc | output | 1 | Group came from the trace cache |
| grpPc | output | ADDR_W | Fetch PC of the group |
| unitReq | output | 3 | Execution-unit demand: ALU, MDU, LSU |

## Verification
Several rules are checked on every cycle. The assertions cover the freeze during a decoder stall and the clean drop after a redirect. They also check that the fetch address steps by one word or jumps to the trace-cache successor, that a trace-cache group is never the first one after reset, and that invalid slots carry class zero. The bench's lockstep model covers what needs real opcodes and addresses: the class of every slot under mixed opcode patterns, the merged demand vector, and the slot mask after a redirect into the middle of a word. It also shows which source is chosen across random hit, stall and redirect sequences.

// File: rtl/tfetch_pkg.sv
package tfetch_pkg;

  localparam int NUM_UNITS = 3;
  localparam int UNIT_ALU  = 0;
  localparam int UNIT_MDU  = 1;
  localparam int UNIT_LSU  = 2;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_ALU   = 2'd1,
    CLS_MDU   = 2'd2,
    CLS_LSU   = 2'd3
  } slotClass_e;

  typedef struct packed {
    logic loadGrp;
    logic takeTc;
    logic redirect;
  } fetchStrobe_t;

endpackage

// File: rtl/tfetch_predecode.sv
module tfetch_predecode
  import tfetch_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               slotOk,
  output slotClass_e         cls
);

  logic isMdu;
  logic isLsu;
  logic isAlu;

  always_comb begin
    isMdu = (instr[15:6] == 10'b0100001101);
    isLsu = (instr[15:11] == 5'b01001) ||
            (instr[15:12] == 4'h5) || (instr[15:12] == 4'h6) ||
            (instr[15:12] == 4'h7) || (instr[15:12] == 4'h8) ||
            (instr[15:12] == 4'h9) || (instr[15:12] == 4'hC);
    isAlu = (instr[15:14] == 2'b00) ||
            ((instr[15:11] == 5'b01000) && !isMdu) ||
            (instr[15:12] == 4'hA) ||
            (instr[15:8] == 8'hB0);
  end

  always_comb begin
    if (!slotOk)     cls = CLS_OTHER;
    else if (isMdu)  cls = CLS_MDU;
    else if (isLsu)  cls = CLS_LSU;
    else if (isAlu)  cls = CLS_ALU;
    else             cls = CLS_OTHER;
  end

endmodule

// File: rtl/tfetch_ctrl.sv
module tfetch_ctrl
  import tfetch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         grpValid,
  input  logic         decReady,
  input  logic         redirValid,
  input  logic         tcHit,
  output fetchStrobe_t strobe,
  output logic         tcLookupEn
);

  logic coldStart;

  always_comb begin
    strobe.redirect = redirValid;
    strobe.loadGrp  = !redirValid && (!grpValid || decReady);
    strobe.takeTc   = tcHit && !coldStart;
    tcLookupEn      = !coldStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coldStart <= 1'b1;
    end else if (strobe.loadGrp) begin
      coldStart <= 1'b0;
    end
  end

endmodule

// File: rtl/tfetch_dp.sv
module tfetch_dp
  import tfetch_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100,
  parameter int              SLOTS    = 4,
  parameter int              INSTR_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fetchStrobe_t          strobe,
  input  logic [ADDR_W-1:0]     redirPc,
  input  logic [SLOTS*INSTR_W-1:0] imemData,
  input  logic [SLOTS*INSTR_W-1:0] tcData,
  input  logic [ADDR_W-1:0]     tcNextPc,
  output logic [ADDR_W-1:0]     pc,
  output logic [ADDR_W-1:0]     imemAddr,
  output logic                  grpValid,
  output logic [SLOTS*INSTR_W-1:0] grpInstr,
  output logic [SLOTS-1:0]      grpSlotValid,
  output logic [2*SLOTS-1:0]    grpClass,
  output logic                  grpFromTc,
  output logic [ADDR_W-1:0]     grpPc,
  output logic [NUM_UNITS-1:0]  unitReq
);

  localparam int GROUP_W = SLOTS * INSTR_W;
  localparam int BYTES   = GROUP_W / 8;
  localparam int OFS_W   = $clog2(BYTES);
  localparam int IDX_W   = $clog2(SLOTS);

  logic [ADDR_W-1:0]  alignedPc;
  logic [IDX_W-1:0]   startSlot;
  logic [GROUP_W-1:0] srcData;
  logic [SLOTS-1:0]   slotOk;
  slotClass_e         slotCls [SLOTS];
  logic [2*SLOTS-1:0] clsFlat;
  logic [NUM_UNITS-1:0] reqNext;
  logic [ADDR_W-1:0]  nextPc;

  always_comb begin
    alignedPc = {pc[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    startSlot = pc[1 +: IDX_W];
    srcData   = strobe.takeTc ? tcData : imemData;
    nextPc    = strobe.takeTc ? {tcNextPc[ADDR_W-1:1], 1'b0}
                              : alignedPc + ADDR_W'(BYTES);
  end

  assign imemAddr = alignedPc;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign slotOk[i] = strobe.takeTc || (IDX_W'(i) >= startSlot);

    tfetch_predecode #(.INSTR_W(INSTR_W)) u_pre (
      .instr  (srcData[i*INSTR_W +: INSTR_W]),
      .slotOk (slotOk[i]),
      .cls    (slotCls[i])
    );

    assign clsFlat[2*i +: 2] = slotCls[i];
  end

  always_comb begin
    reqNext = '0;
    for (int i = 0; i < SLOTS; i++) begin
      unique case (slotCls[i])
        CLS_ALU: reqNext[UNIT_ALU] = 1'b1;
        CLS_MDU: reqNext[UNIT_MDU] = 1'b1;
        CLS_LSU: reqNext[UNIT_LSU] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc           <= RESET_PC;
      grpValid     <= 1'b0;
      grpInstr     <= '0;
      grpSlotValid <= '0;
      grpClass     <= '0;
      grpFromTc    <= 1'b0;
      grpPc        <= '0;
      unitReq      <= '0;
    end else if (strobe.redirect) begin
      pc           <= {redirPc[ADDR_W-1:1], 1'b0};
      grpValid     <= 1'b0;
      grpSlotValid <= '0;
      grpClass     <= '0;
      unitReq      <= '0;
    end else if (strobe.loadGrp) begin
      pc           <= nextPc;
      grpValid     <= 1'b1;
      grpInstr     <= srcData;
      grpSlotValid <= slotOk;
      grpClass     <= clsFlat;
      grpFromTc    <= strobe.takeTc;
      grpPc        <= pc;
      unitReq      <= reqNext;
    end
  end

endmodule

// File: rtl/trace_fetch_sel.sv
module trace_fetch_sel
  import tfetch_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100,
  parameter int                SLOTS    = 4,
  parameter int                INSTR_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  output logic [ADDR_W-1:0]        imemAddr,
  input  logic [SLOTS*INSTR_W-1:0] imemData,
  output logic                     tcLookupEn,
  output logic [ADDR_W-1:0]        tcLookupAddr,
  input  logic                     tcHit,
  input  logic [SLOTS*INSTR_W-1:0] tcData,
  input  logic [ADDR_W-1:0]        tcNextPc,
  input  logic                     redirValid,
  input  logic [ADDR_W-1:0]        redirPc,
  output logic                     grpValid,
  input  logic                     decReady,
  output logic [SLOTS*INSTR_W-1:0] grpInstr,
  output logic [SLOTS-1:0]         grpSlotValid,
  output logic [2*SLOTS-1:0]       grpClass,
  output logic                     grpFromTc,
  output logic [ADDR_W-1:0]        grpPc,
  output logic [NUM_UNITS-1:0]     unitReq
);

  fetchStrobe_t strobe;
  logic [ADDR_W-1:0] pc;

  tfetch_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .grpValid   (grpValid),
    .decReady   (decReady),
    .redirValid (redirValid),
    .tcHit      (tcHit),
    .strobe     (strobe),
    .tcLookupEn (tcLookupEn)
  );

  tfetch_dp #(
    .ADDR_W   (ADDR_W),
    .RESET_PC (RESET_PC),
    .SLOTS    (SLOTS),
    .INSTR_W  (INSTR_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .redirPc      (redirPc),
    .imemData     (imemData),
    .tcData       (tcData),
    .tcNextPc     (tcNextPc),
    .pc           (pc),
    .imemAddr     (imemAddr),
    .grpValid     (grpValid),
    .grpInstr     (grpInstr),
    .grpSlotValid (grpSlotValid),
    .grpClass     (grpClass),
    .grpFromTc    (grpFromTc),
    .grpPc        (grpPc),
    .unitReq      (unitReq)
  );

  assign tcLookupAddr = pc;

endmodule

// File: rtl/trace_fetch_sel_chk.sv
module trace_fetch_sel_chk #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100,
  parameter int                SLOTS    = 4,
  parameter int                INSTR_W  = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [ADDR_W-1:0]        imemAddr,
  input logic [SLOTS*INSTR_W-1:0] imemData,
  input logic                     tcLookupEn,
  input logic [ADDR_W-1:0]        tcLookupAddr,
  input logic                     tcHit,
  input logic [SLOTS*INSTR_W-1:0] tcData,
  input logic [ADDR_W-1:0]        tcNextPc,
  input logic                     redirValid,
  input logic [ADDR_W-1:0]        redirPc,
  input logic                     grpValid,
  input logic                     decReady,
  input logic [SLOTS*INSTR_W-1:0] grpInstr,
  input logic [SLOTS-1:0]         grpSlotValid,
  input logic [2*SLOTS-1:0]       grpClass,
  input logic                     grpFromTc,
  input logic [ADDR_W-1:0]        grpPc,
  input logic [2:0]               unitReq
);

  logic firstSeen;
  logic loadNow;

  assign loadNow = !redirValid && (!grpValid || decReady);

  always_ff @(posedge clk) begin
    if (!rstN)         firstSeen <= 1'b0;
    else if (grpValid) firstSeen <= 1'b1;
  end

  AST_COLD_FROM_IMEM: assert property (@(posedge clk) disable iff (!rstN)
    (grpValid && !firstSeen) |-> !grpFromTc); // R2

  AST_IMEM_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (loadNow && !(tcHit && tcLookupEn)) |=> (tcLookupAddr == $past(imemAddr) + ADDR_W'(8))); // R6

  AST_TC_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (loadNow && tcHit && tcLookupEn) |=>
      (grpFromTc && (&grpSlotValid) && tcLookupAddr == ($past(tcNextPc) & ~ADDR_W'(1)))); // R5

  AST_LAST_SLOT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    grpValid |-> grpSlotValid[SLOTS-1]); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (grpValid && !decReady && !redirValid) |=>
      (grpValid && $stable(grpInstr) && $stable(unitReq) && $stable(grpClass) &&
       $stable(grpSlotValid) && $stable(tcLookupAddr))); // R9

  AST_REDIR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |=> (!grpValid && unitReq == 3'b000 &&
                    tcLookupAddr == ($past(redirPc) & ~ADDR_W'(1)))); // R10

  AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !grpValid |-> (unitReq == 3'b000 && grpSlotValid == '0)); // R8

  for (genvar i = 0; i < SLOTS; i++) begin : g_cls
    AST_INVALID_SLOT_CLASS: assert property (@(posedge clk) disable iff (!rstN)
      !grpSlotValid[i] |-> (grpClass[2*i +: 2] == 2'd0)); // R8
  end

endmodule

bind trace_fetch_sel trace_fetch_sel_chk #(
  .ADDR_W   (ADDR_W),
  .RESET_PC (RESET_PC),
  .SLOTS    (SLOTS),
  .INSTR_W  (INSTR_W)
) u_chk (.*);

// File: tb/trace_fetch_sel_bench.sv
module trace_fetch_sel_bench;

  localparam int          AW  = 32;
  localparam logic [31:0] RPC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] imemAddr;
  logic [63:0] imemData;
  logic        tcLookupEn;
  logic [31:0] tcLookupAddr;
  logic        tcHit;
  logic [63:0] tcData;
  logic [31:0] tcNextPc;
  logic        redirValid;
  logic [31:0] redirPc;
  logic        grpValid;
  logic        decReady;
  logic [63:0] grpInstr;
  logic [3:0]  grpSlotValid;
  logic [7:0]  grpClass;
  logic        grpFromTc;
  logic [31:0] grpPc;
  logic [2:0]  unitReq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trace_fetch_sel u_trace_fetch_sel (.*);

  function automatic logic [15:0] opSel(int k);
    case (k & 7)
      0: return 16'h1C08;
      1: return 16'h4348;
      2: return 16'h6808;
      3: return 16'hD001;
      4: return 16'h4008;
      5: return 16'h9801;
      6: return 16'hB500;
      default: return 16'hB080;
    endcase
  endfunction

  function automatic logic [63:0] memWord(logic [31:0] a);
    logic [63:0] w;
    for (int i = 0; i < 4; i++) begin
      int h;
      h = int'((a >> 1) & 32'h00FF_FFFF) + i;
      w[16*i +: 16] = opSel(h * 3 + (h >> 4));
    end
    return w;
  endfunction

  function automatic logic [1:0] classOf(logic [15:0] x);
    logic mdu, lsu, alu;
    mdu = (x[15:6] == 10'b0100001101);
    lsu = (x[15:11] == 5'b01001) || (x[15:12] == 4'h5) || (x[15:12] == 4'h6) ||
          (x[15:12] == 4'h7) || (x[15:12] == 4'h8) || (x[15:12] == 4'h9) ||
          (x[15:12] == 4'hC);
    alu = (x[15:14] == 2'b00) || ((x[15:11] == 5'b01000) && !mdu) ||
          (x[15:12] == 4'hA) || (x[15:8] == 8'hB0);
    if (mdu) return 2'd2;
    if (lsu) return 2'd3;
    if (alu) return 2'd1;
    return 2'd0;
  endfunction

  always_comb imemData = memWord(imemAddr);

  logic [31:0] mPc;
  logic        mCold, mValid, mFromTc;
  logic [63:0] mInstr;
  logic [3:0]  mSlot;
  logic [7:0]  mCls;
  logic [2:0]  mReq;
  logic [31:0] mGrpPc;
  string       mTag;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic stepModel();
    if (redirValid) begin
      mPc = redirPc & ~32'd1; mValid = 0; mSlot = 0; mCls = 0; mReq = 0;
      mTag = "R10";
    end else if (!mValid || decReady) begin
      logic useTc;
      logic [31:0] al;
      useTc = tcHit && !mCold;
      al = {mPc[31:3], 3'b000};
      mInstr = useTc ? tcData : memWord(al);
      mReq = 0; mCls = 0;
      for (int i = 0; i < 4; i++) begin
        mSlot[i] = useTc || (i >= int'(mPc[2:1]));
        if (mSlot[i]) begin
          mCls[2*i +: 2] = classOf(mInstr[16*i +: 16]);
          if (mCls[2*i +: 2] == 2'd1) mReq[0] = 1;
          if (mCls[2*i +: 2] == 2'd2) mReq[1] = 1;
          if (mCls[2*i +: 2] == 2'd3) mReq[2] = 1;
        end
      end
      mTag = useTc ? "R5" : (mCold ? "R2" : "R6");
      mGrpPc = mPc; mFromTc = useTc; mValid = 1;
      mPc = useTc ? (tcNextPc & ~32'd1) : al + 32'd8;
      mCold = 0;
    end else begin
      mTag = "R9";
    end
  endtask

  task automatic checkAll();
    chk(grpValid == mValid, mTag, "grpValid", 64'(grpValid), 64'(mValid));
    chk(tcLookupAddr == mPc, mTag, "tcLookupAddr", 64'(tcLookupAddr), 64'(mPc));
    chk(imemAddr == {mPc[31:3], 3'b000}, "R3", "imemAddr", 64'(imemAddr), 64'({mPc[31:3], 3'b000}));
    chk(tcLookupEn == !mCold, "R2", "tcLookupEn", 64'(tcLookupEn), 64'(!mCold));
    chk(grpSlotValid == mSlot, "R4", "grpSlotValid", 64'(grpSlotValid), 64'(mSlot));
    chk(grpClass == mCls, "R7", "grpClass", 64'(grpClass), 64'(mCls));
    chk(unitReq == mReq, "R8", "unitReq", 64'(unitReq), 64'(mReq));
    if (mValid) begin
      chk(grpInstr == mInstr, mTag, "grpInstr", grpInstr, mInstr);
      chk(grpFromTc == mFromTc, mTag, "grpFromTc", 64'(grpFromTc), 64'(mFromTc));
      chk(grpPc == mGrpPc, "R11", "grpPc", 64'(grpPc), 64'(mGrpPc));
    end
  endtask

  function automatic logic [63:0] randGroup();
    logic [63:0] g;
    for (int i = 0; i < 4; i++) g[16*i +: 16] = opSel(int'($urandom % 8));
    return g;
  endfunction

  task automatic cycle();
    @(posedge clk);
    stepModel();
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; tcHit = 0; tcData = 0; tcNextPc = 0;
    redirValid = 0; redirPc = 0; decReady = 0;
    mPc = RPC; mCold = 1; mValid = 0; mFromTc = 0; mInstr = 0;
    mSlot = 0; mCls = 0; mReq = 0; mGrpPc = 0; mTag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk(grpValid == 0 && unitReq == 0 && grpSlotValid == 0 && grpClass == 0, "R1",
        "reset outputs", {grpValid, unitReq, grpSlotValid, grpClass}, 64'd0);
    chk(tcLookupAddr == RPC && tcLookupEn == 0, "R1", "reset pc",
        {tcLookupEn, tcLookupAddr}, {1'b0, RPC});

    // R2 first group from memory despite a hit
    tcHit = 1; tcData = randGroup(); tcNextPc = 32'h0000_4000; decReady = 0;
    cycle();
    chk(grpFromTc == 0, "R2", "cold source", 64'(grpFromTc), 64'd0);

    // R9 stall: hold for several cycles
    decReady = 0; tcHit = 1;
    repeat (3) cycle();

    // R5 hit now honoured
    decReady = 1; tcData = randGroup();
    cycle();
    chk(grpFromTc == 1 && grpSlotValid == 4'hF, "R5", "tc group",
        {grpFromTc, grpSlotValid}, {1'b1, 4'hF});

    // R10 redirect into slot 3 then R4 mask
    redirValid = 1; redirPc = 32'h0000_0206; tcHit = 0;
    cycle();
    redirValid = 0;
    cycle();
    chk(grpSlotValid == 4'b1000, "R4", "mid-word mask", 64'(grpSlotValid), 64'h8);
    cycle();
    chk(grpSlotValid == 4'hF && grpPc == 32'h208, "R6", "next word",
        {grpSlotValid, grpPc}, {4'hF, 32'h208});

    // random mix
    for (int n = 0; n < 4000; n++) begin
      decReady   = ($urandom % 4) != 0;
      tcHit      = ($urandom % 3) == 0;
      tcData     = randGroup();
      tcNextPc   = 32'h0000_1000 + ($urandom % 512);
      redirValid = ($urandom % 16) == 0;
      redirPc    = 32'h0000_0200 + (($urandom % 256) << 1);
      cycle();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule